// File: doc/BRIEF.md
# Pulse Generator Configuration Register Slave

This block is the register file of a programmable pulse generator. It sits on a 16-bit address bus as a slave that moves 16-bit words. It answers only inside a 64-byte window. The window starts at C000h plus 64 times an 8-bit logical address. In that window it returns fixed identification words and a status word. It also holds the timing and mode words that drive a pulse sequencer, and it stores two 12-bit level codes for the output reference converters.

Software writes the interval, delay, width and mode words and reads them back. It loads the two level codes, which cannot be read back. It can restart the block by writing a 1 to bit 0 of the status word. Each stored field also appears on a dedicated output for the sequencer and the converters. The bus handshake is a single-cycle strobe. An acknowledge returns on the next cycle, and read data comes with it.

Top module: `pulse_cfg_regs`

## Requirements
- R1: A strobe whose address lies in [C000h + 64*logAddr, C000h + 64*logAddr + 63] gets `busAck` high for exactly one cycle, on the cycle after the strobe. A strobe outside that window gets no acknowledge. Address bit 0 is ignored, and the word offset is `busAddr[5:0]`.
- R2: Offset 00h reads FFC1h. This is register-based class 11b in bits 15:14, 16-bit addressing 11b in bits 13:12 and vendor code FC1h in bits 11:0. Writes to this offset change nothing.
- R3: Offset 02h reads FFFDh, which is four ones above model code FFDh. Writes to this offset change nothing.
- R4: Offset 04h reads the status word. Bit 15 is the `modSel` input, bit 14 is 0, bits 13:8 are ones, bits 7:4 are zero, bit 3 is Ready, bit 2 is Pass and bits 1:0 are ones.
- R5: Offset 08h is the interval word. Bit 15 is the output enable, bits 14:12 are the range and bits 9:0 are the multiplier. It reads back as written, with bits 11:10 reading 0, and its fields appear on `outEnable`, `intervalRange` and `intervalMult`.
- R6: Offset 0Ah is the delay word. Only bits 9:0 are kept, and they read back and appear on `delayMult`.
- R7: Offset 0Ch is the width word. Bits 14:12 hold the range and bits 9:0 the multiplier, and both read back. Bits 15 and 11:10 read 0. The fields appear on `widthRange` and `widthMult`.
- R8: Offset 0Eh is the mode word. Bits 1:0 are the waveform mode, bit 2 is free run, bit 3 is delayed, bit 4 is gated, bit 5 is run and bit 6 is double pulse. Bits 15:7 read 0, and each field appears on its own output.
- R9: Offsets 10h (low) and 12h (high) take 12-bit level codes from bits 11:0. The codes appear on `lowRefCode` and `highRefCode`, both offsets read FFFFh, and both codes reset to 800h, which is midscale zero.
- R10: Offset 06h and every in-window offset from 14h upward read 0000h, and writes to them change nothing.
- R11: Writing 1 to bit 0 at offset 04h starts a reset. All timing, mode and level storage returns to its reset value, and Ready reads 0 for RESET_CYCLES cycles. Writes during that time are ignored, and Pass keeps its value.
- R12: After the reset input is released, Ready and Pass read 0. Ready rises after RESET_CYCLES cycles, and Pass rises with it and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| logAddr | input | 8 | Logical address that places the window |
| busStb | input | 1 | Single-cycle access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte address |
| busWdata | input | 16 | Write data |
| modSel | input | 1 | Module-select line, reported in status bit 15 |
| busAck | output | 1 | Acknowledge, one cycle after an in-window strobe |
| busRdata | output | 16 | Read data, valid with the acknowledge |
| ready | output | 1 | Block is out of its reset sequence |
| outEnable | output | 1 | Output relay enable |
| intervalRange | output | 3 | Interval and delay time base |
| intervalMult | output | 10 | Interval multiplier |
| delayMult | output | 10 | Delay multiplier |
| widthRange | output | 3 | Width time base |
| widthMult | output | 10 | Width multiplier |
| waveMode | output | 2 | Waveform mode |
| freeRun | output | 1 | Free-running trigger mode |
| delayedMode | output | 1 | Delayed pulse mode |
| gatedMode | output | 1 | Gated trigger mode |
| runEnable | output | 1 | Pulse generation on |
| doublePulse | output | 1 | Double pulse mode |
| lowRefCode | output | 12 | Low level converter code |
| highRefCode | output | 12 | High level converter code |

## Verification
The bench drives a strobe for one cycle. The acknowledge and read data appear after that one clock edge, so the bench samples them at the following falling edge, and the same holds for the exported fields after a write. A self-reset write drops Ready at the edge that takes the strobe. The bench then counts falling edges until Ready returns and expects exactly RESET_CYCLES. Out-of-window strobes are checked by looking for the absence of an acknowledge in that same sampling slot.

// File: rtl/pulse_cfg_pkg.sv
package pulse_cfg_pkg;
  localparam int WORD_W   = 16;
  localparam int WIN_BITS = 6;
  localparam int IDX_W    = WIN_BITS - 1;

  localparam logic [IDX_W-1:0] IDX_ID       = 5'd0;
  localparam logic [IDX_W-1:0] IDX_TYPE     = 5'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS   = 5'd2;
  localparam logic [IDX_W-1:0] IDX_INTERVAL = 5'd4;
  localparam logic [IDX_W-1:0] IDX_LOWREF   = 5'd8;

  localparam int NUM_RW  = 4;
  localparam int NUM_REF = 2;
  localparam int REF_W   = 12;
  localparam logic [REF_W-1:0] REF_MID = 12'h800;

  // keep masks, index 0 = interval, 1 = delay, 2 = width, 3 = mode
  localparam logic [NUM_RW-1:0][WORD_W-1:0] RW_MASK =
    {16'h007F, 16'h73FF, 16'h03FF, 16'hF3FF};

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             clearAll;
    logic [IDX_W-1:0] wordIdx;
  } cfgStrobe_t;
endpackage

// File: rtl/pulse_cfg_ctrl.sv
module pulse_cfg_ctrl
  import pulse_cfg_pkg::*;
#(
  parameter int          LA_WIDTH     = 8,
  parameter logic [15:0] BASE_ADDR    = 16'hC000,
  parameter int          RESET_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LA_WIDTH-1:0] logAddr,
  input  logic                busStb,
  input  logic                busWe,
  input  logic [15:0]         busAddr,
  input  logic                resetBit,
  output cfgStrobe_t          strobe,
  output logic                busAck,
  output logic                ready,
  output logic                pass
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic [15:0]      winBase;
  logic             hit;
  logic             selfReset;
  logic             resetting;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wordIdx;

  assign winBase   = BASE_ADDR + (16'(logAddr) << WIN_BITS);
  assign hit       = busStb && (busAddr[15:WIN_BITS] == winBase[15:WIN_BITS]);
  assign wordIdx   = busAddr[WIN_BITS-1:1];
  assign resetting = (cnt != '0);
  assign selfReset = hit && busWe && (wordIdx == IDX_STATUS) && resetBit;

  always_comb begin
    strobe.wrEn     = hit && busWe && !resetting && !selfReset;
    strobe.rdEn     = hit && !busWe;
    strobe.clearAll = selfReset || resetting;
    strobe.wordIdx  = wordIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= CNT_W'(RESET_CYCLES);
      busAck <= 1'b0;
      pass   <= 1'b0;
    end else begin
      busAck <= hit;
      if (selfReset) cnt <= CNT_W'(RESET_CYCLES);
      else if (resetting) cnt <= cnt - 1'b1;
      if (!selfReset && cnt == CNT_W'(1)) pass <= 1'b1;
    end
  end

  assign ready = !resetting;
endmodule

// File: rtl/pulse_cfg_data.sv
module pulse_cfg_data
  import pulse_cfg_pkg::*;
#(
  parameter logic [11:0] MFR_CODE   = 12'hFC1,
  parameter logic [11:0] MODEL_CODE = 12'hFFD
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgStrobe_t                     strobe,
  input  logic [WORD_W-1:0]              busWdata,
  input  logic                           modSel,
  input  logic                           ready,
  input  logic                           pass,
  output logic [WORD_W-1:0]              busRdata,
  output logic [NUM_RW-1:0][WORD_W-1:0]  rwQ,
  output logic [NUM_REF-1:0][REF_W-1:0]  refQ
);
  logic [WORD_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_RW; g++) begin : gRw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rwQ[g] <= '0;
      else if (strobe.clearAll) rwQ[g] <= '0;
      else if (strobe.wrEn && strobe.wordIdx == IDX_W'(int'(IDX_INTERVAL) + g))
        rwQ[g] <= busWdata & RW_MASK[g];
    end
  end

  for (genvar h = 0; h < NUM_REF; h++) begin : gRef
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) refQ[h] <= REF_MID;
      else if (strobe.clearAll) refQ[h] <= REF_MID;
      else if (strobe.wrEn && strobe.wordIdx == IDX_W'(int'(IDX_LOWREF) + h))
        refQ[h] <= busWdata[REF_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    if (strobe.wordIdx == IDX_ID)
      rdMux = {2'b11, 2'b11, MFR_CODE};
    else if (strobe.wordIdx == IDX_TYPE)
      rdMux = {4'hF, MODEL_CODE};
    else if (strobe.wordIdx == IDX_STATUS)
      rdMux = {modSel, 1'b0, 6'h3F, 4'h0, ready, pass, 2'b11};
    else if (strobe.wordIdx >= IDX_INTERVAL &&
             strobe.wordIdx < IDX_W'(int'(IDX_INTERVAL) + NUM_RW))
      rdMux = rwQ[strobe.wordIdx - IDX_INTERVAL];
    else if (strobe.wordIdx >= IDX_LOWREF &&
             strobe.wordIdx < IDX_W'(int'(IDX_LOWREF) + NUM_REF))
      rdMux = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else busRdata <= strobe.rdEn ? rdMux : '0;
  end
endmodule

// File: rtl/pulse_cfg_regs.sv
module pulse_cfg_regs
  import pulse_cfg_pkg::*;
#(
  parameter int          LA_WIDTH     = 8,
  parameter logic [15:0] BASE_ADDR    = 16'hC000,
  parameter int          RESET_CYCLES = 4,
  parameter logic [11:0] MFR_CODE     = 12'hFC1,
  parameter logic [11:0] MODEL_CODE   = 12'hFFD
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LA_WIDTH-1:0] logAddr,
  input  logic                busStb,
  input  logic                busWe,
  input  logic [15:0]         busAddr,
  input  logic [15:0]         busWdata,
  input  logic                modSel,
  output logic                busAck,
  output logic [15:0]         busRdata,
  output logic                ready,
  output logic                outEnable,
  output logic [2:0]          intervalRange,
  output logic [9:0]          intervalMult,
  output logic [9:0]          delayMult,
  output logic [2:0]          widthRange,
  output logic [9:0]          widthMult,
  output logic [1:0]          waveMode,
  output logic                freeRun,
  output logic                delayedMode,
  output logic                gatedMode,
  output logic                runEnable,
  output logic                doublePulse,
  output logic [11:0]         lowRefCode,
  output logic [11:0]         highRefCode
);
  cfgStrobe_t                    strobe;
  logic                          pass;
  logic [NUM_RW-1:0][WORD_W-1:0] rwQ;
  logic [NUM_REF-1:0][REF_W-1:0] refQ;

  pulse_cfg_ctrl #(
    .LA_WIDTH(LA_WIDTH), .BASE_ADDR(BASE_ADDR), .RESET_CYCLES(RESET_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .logAddr(logAddr), .busStb(busStb),
    .busWe(busWe), .busAddr(busAddr), .resetBit(busWdata[0]),
    .strobe(strobe), .busAck(busAck), .ready(ready), .pass(pass)
  );

  pulse_cfg_data #(.MFR_CODE(MFR_CODE), .MODEL_CODE(MODEL_CODE)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .modSel(modSel), .ready(ready), .pass(pass), .busRdata(busRdata),
    .rwQ(rwQ), .refQ(refQ)
  );

  assign outEnable     = rwQ[0][15];
  assign intervalRange = rwQ[0][14:12];
  assign intervalMult  = rwQ[0][9:0];
  assign delayMult     = rwQ[1][9:0];
  assign widthRange    = rwQ[2][14:12];
  assign widthMult     = rwQ[2][9:0];
  assign waveMode      = rwQ[3][1:0];
  assign freeRun       = rwQ[3][2];
  assign delayedMode   = rwQ[3][3];
  assign gatedMode     = rwQ[3][4];
  assign runEnable     = rwQ[3][5];
  assign doublePulse   = rwQ[3][6];
  assign lowRefCode    = refQ[0];
  assign highRefCode   = refQ[1];
endmodule

// File: rtl/pulse_cfg_regs_check.sv
module pulse_cfg_regs_check #(
  parameter int          LA_WIDTH  = 8,
  parameter logic [15:0] BASE_ADDR = 16'hC000
) (
  input logic                clk,
  input logic                rstN,
  input logic [LA_WIDTH-1:0] logAddr,
  input logic                busStb,
  input logic                busWe,
  input logic [15:0]         busAddr,
  input logic [15:0]         busWdata,
  input logic                busAck,
  input logic [15:0]         busRdata,
  input logic                ready,
  input logic                runEnable,
  input logic                outEnable
);
  logic [16:0] lo, hi;
  logic        inWin;
  logic [5:0]  off;

  assign lo    = {1'b0, BASE_ADDR} + {3'b0, logAddr, 6'b0};
  assign hi    = lo + 17'd64;
  assign inWin = ({1'b0, busAddr} >= lo) && ({1'b0, busAddr} < hi);
  assign off   = busAddr[5:0] & 6'h3E;

  assert_ack_in_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && inWin) |=> busAck);
  assert_ack_needs_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busStb && inWin));
  assert_id_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && inWin && !busWe && off == 6'h00) |=> busRdata == 16'hFFC1);
  assert_ref_reads_ones_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && inWin && !busWe && (off == 6'h10 || off == 6'h12)) |=> busRdata == 16'hFFFF);
  assert_self_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && inWin && busWe && off == 6'h04 && busWdata[0]) |=>
      (!ready && !runEnable && !outEnable));
  assert_quiet_in_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (!runEnable && !outEnable));
endmodule

bind pulse_cfg_regs pulse_cfg_regs_check #(.LA_WIDTH(LA_WIDTH), .BASE_ADDR(BASE_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .logAddr(logAddr), .busStb(busStb), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata),
  .ready(ready), .runEnable(runEnable), .outEnable(outEnable)
);

// File: tb/pulse_cfg_regs_test.sv
module pulse_cfg_regs_test;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] logAddr = 8'h00;
  logic busStb = 1'b0, busWe = 1'b0, modSel = 1'b0;
  logic [15:0] busAddr = 16'h0, busWdata = 16'h0;
  logic busAck, ready, outEnable, freeRun, delayedMode, gatedMode, runEnable, doublePulse;
  logic [15:0] busRdata;
  logic [2:0] intervalRange, widthRange;
  logic [9:0] intervalMult, delayMult, widthMult;
  logic [1:0] waveMode;
  logic [11:0] lowRefCode, highRefCode;

  int nChecks = 0, nFails = 0;
  logic [15:0] shInt, shDel, shWid, shMode;
  logic [11:0] shLow, shHigh;

  always #5 clk = ~clk;

  pulse_cfg_regs #(.RESET_CYCLES(RST_CYC)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] base();
    return 16'hC000 + {logAddr, 6'b0};
  endfunction

  function automatic logic [15:0] expRead(input logic [5:0] off, input logic rdy, input logic ps);
    case (off & 6'h3E)
      6'h00: return 16'hFFC1;
      6'h02: return 16'hFFFD;
      6'h04: return {modSel, 1'b0, 6'h3F, 4'h0, rdy, ps, 2'b11};
      6'h08: return shInt;
      6'h0A: return shDel;
      6'h0C: return shWid;
      6'h0E: return shMode;
      6'h10, 6'h12: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic access(input logic [15:0] addr, input logic we, input logic [15:0] wd,
                        output logic ack, output logic [15:0] rd);
    busAddr = addr; busWe = we; busWdata = wd; busStb = 1'b1;
    @(negedge clk);
    ack = busAck; rd = busRdata;
    busStb = 1'b0; busWe = 1'b0;
  endtask

  task automatic shadowWrite(input logic [5:0] off, input logic [15:0] wd);
    case (off & 6'h3E)
      6'h08: shInt  = wd & 16'hF3FF;
      6'h0A: shDel  = wd & 16'h03FF;
      6'h0C: shWid  = wd & 16'h73FF;
      6'h0E: shMode = wd & 16'h007F;
      6'h10: shLow  = wd[11:0];
      6'h12: shHigh = wd[11:0];
      default: ;
    endcase
  endtask

  task automatic checkFields(input string tag);
    chk({tag, " R5 oen"}, outEnable, shInt[15]);
    chk({tag, " R5 rng"}, intervalRange, shInt[14:12]);
    chk({tag, " R5 mult"}, intervalMult, shInt[9:0]);
    chk({tag, " R6 dly"}, delayMult, shDel[9:0]);
    chk({tag, " R7 wid"}, {widthRange, widthMult}, {shWid[14:12], shWid[9:0]});
    chk({tag, " R8 mode"}, {doublePulse, runEnable, gatedMode, delayedMode, freeRun, waveMode},
        shMode[6:0]);
    chk({tag, " R9 refs"}, {lowRefCode, highRefCode}, {shLow, shHigh});
  endtask

  task automatic clearShadow();
    shInt = 0; shDel = 0; shWid = 0; shMode = 0; shLow = 12'h800; shHigh = 12'h800;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic ack;
    logic [15:0] rd;
    int n;
    clearShadow();
    logAddr = 8'($urandom(32'd771));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state, R12 and R9 midscale
    chk("R12 ready after reset", ready, 1'b0);
    checkFields("reset");
    access(base() + 16'h04, 1'b0, 16'h0, ack, rd);
    chk("R4 R12 status during power reset", rd, 16'h3F03);
    n = 0;
    while (!ready && n < 20) begin @(negedge clk); n++; end
    chk("R12 ready rises", ready, 1'b1);
    modSel = 1'b1;
    access(base() + 16'h04, 1'b0, 16'h0, ack, rd);
    chk("R4 R12 status ready pass modSel", rd, 16'hBF0F);
    modSel = 1'b0;

    // identification words, writes ignored (R2, R3)
    access(base(), 1'b1, 16'h1234, ack, rd);
    access(base(), 1'b0, 16'h0, ack, rd);
    chk("R2 id word", rd, 16'hFFC1);
    access(base() + 16'h02, 1'b1, 16'h0000, ack, rd);
    access(base() + 16'h02, 1'b0, 16'h0, ack, rd);
    chk("R3 type word", rd, 16'hFFFD);

    // window edges (R1) and spare offsets (R10)
    access(base() + 16'd64, 1'b0, 16'h0, ack, rd);
    chk("R1 above window no ack", ack, 1'b0);
    access(base() - 16'd2, 1'b1, 16'hFFFF, ack, rd);
    chk("R1 below window no ack", ack, 1'b0);
    access(base() + 16'd63, 1'b0, 16'h0, ack, rd);
    chk("R1 last byte ack", ack, 1'b1);
    chk("R10 high spare reads zero", rd, 16'h0000);
    access(base() + 16'h06, 1'b1, 16'hBEEF, ack, rd);
    access(base() + 16'h06, 1'b0, 16'h0, ack, rd);
    chk("R10 offset 06 reads zero", rd, 16'h0000);
    checkFields("R10 spare write");

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      logic [5:0] off;
      logic we;
      logic [15:0] wd;
      off = 6'(($urandom % 11) * 2);
      if (off == 6'h14) off = 6'h2A;
      we = 1'($urandom % 2);
      wd = 16'($urandom);
      if ((off & 6'h3E) == 6'h04) wd[0] = 1'b0;
      access(base() + {10'b0, off} + 16'($urandom % 2), we, wd, ack, rd);
      chk("R1 random ack", ack, 1'b1);
      if (we) begin
        shadowWrite(off, wd);
        checkFields("random");
      end else begin
        chk($sformatf("R5 R6 R7 R8 R9 R10 readback off %h", off), rd, expRead(off, 1'b1, 1'b1));
      end
    end

    // self-reset timing (R11)
    access(base() + 16'h08, 1'b1, 16'hFFFF, ack, rd);
    access(base() + 16'h0E, 1'b1, 16'h007F, ack, rd);
    access(base() + 16'h10, 1'b1, 16'h0123, ack, rd);
    access(base() + 16'h04, 1'b1, 16'h0001, ack, rd);
    chk("R11 reset ack", ack, 1'b1);
    chk("R11 ready drops", ready, 1'b0);
    clearShadow();
    checkFields("R11 cleared");
    n = 0;
    while (!ready && n < 20) begin @(negedge clk); n++; end
    chk("R11 ready low cycles", n, RST_CYC);
    access(base() + 16'h04, 1'b0, 16'h0, ack, rd);
    chk("R11 pass kept", rd, 16'h3F0F);

    // writes ignored during self-reset (R11)
    access(base() + 16'h04, 1'b1, 16'hFFFF, ack, rd);
    access(base() + 16'h08, 1'b1, 16'hFFFF, ack, rd);
    access(base() + 16'h04, 1'b0, 16'h0, ack, rd);
    chk("R11 R4 status mid reset", rd, 16'h3F07);
    while (!ready) @(negedge clk);
    access(base() + 16'h08, 1'b0, 16'h0, ack, rd);
    chk("R11 write during reset ignored", rd, 16'h0000);

    // logical address extremes (R1)
    logAddr = 8'h00;
    access(16'hC000, 1'b0, 16'h0, ack, rd);
    chk("R1 LA 0 ack", ack, 1'b1);
    chk("R1 R2 LA 0 id", rd, 16'hFFC1);
    logAddr = 8'hFF;
    access(16'hFFC2, 1'b0, 16'h0, ack, rd);
    chk("R1 R3 LA 255 type", rd, 16'hFFFD);
    access(16'hC000, 1'b0, 16'h0, ack, rd);
    chk("R1 LA 255 old base no ack", ack, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule